// File: doc/BRIEF.md
# Multi-Channel Interval Timer

This block holds one shared interval timer and one profiling timer for each processor, up to four. Every timer has a count register and a limit register. Each cycle in which the one-microsecond enable `tick_us` is high, every count moves up by one. When a count is about to reach its limit, it goes back to 1 and the timer's interrupt is latched. The shared timer drives the level-10 interrupt line. Each processor timer drives its own level-14 line.

The count and the limit are held in bits 31:10 of each register word. A period of P microseconds is therefore programmed by writing (P+1) shifted left by 10. Software acknowledges an interrupt by reading the timer's limit register. Writing a limit restarts that timer. A limit of zero makes a timer count freely and never interrupt, which is how profiling is switched off.

The registers sit behind a simple word bus. Read data is combinational on `bus_rdata` while `bus_rd` is high. Side effects take place at the clock edge that ends the access.

Top module: `itimer_block`

## Requirements
- R1: After a synchronous active-low reset, every count reads 1 (0x0000_0400), every limit reads 0, and all interrupt outputs are low.
- R2: The count field is bits 31:10 of both register kinds. Bits 9:0 always read as zero, and any value written to them is dropped.
- R3: Each clock cycle with `tick_us` high advances every count by one. Cycles with `tick_us` low leave every count unchanged.
- R4: With a limit field L of 2 or more, the count runs through 1 to L-1. On the tick at which count+1 reaches L, the count returns to 1 and the interrupt sets, so the interrupt comes every L-1 ticks. A limit field of 1 behaves like 2.
- R5: Once set, an interrupt stays high until its limit register is read or written. Reading the count register does not clear it.
- R6: Reading a timer's limit register clears that timer's interrupt only. If the same edge also wraps that timer, the interrupt stays set.
- R7: Writing a limit register stores the new field, sets that timer's count to 1 and clears its interrupt. This takes priority over a tick on the same edge.
- R8: With a limit field of 0, a timer keeps counting and never raises its interrupt. From the all-ones count it steps to 1.
- R9: Address map (bits 1:0 ignored): processor timer n occupies page n at a 4096-byte stride, and the shared timer occupies page NCPU. Within a page, offset 0x0 is the limit and offset 0x4 is the count. Any other location reads 0, and writes to it have no effect.
- R10: Count registers are read-only. A write to one leaves the count unchanged.
- R11: The shared timer drives only `irq_sys_lvl10`. Processor timer n drives only bit n of `irq_cpu_lvl14`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-microsecond count enable |
| bus_addr | input | ADDR_W (16) | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears the interrupt on a limit read) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data, zero when not reading |
| irq_sys_lvl10 | output | 1 | Shared timer interrupt |
| irq_cpu_lvl14 | output | NCPU (4) | Per-processor profiling interrupts |

## Verification
The main counting path is driven from a vector table. The table covers the smallest useful limit, several mid-range limits read both before and after their first wrap, a long limit, and a zero limit. These patterns separate an off-by-one in the wrap compare from a count that restarts at 0 instead of 1, and they separate a free-running timer from one that interrupts on zero. The entries are spread across the shared timer and several processor timers, so a wrong page decode or crossed interrupt wiring shows up as a mismatch on the wrong line. Directed cases then cover collisions on a single edge: a read and a wrap together, and a write and a tick together. They also check that a count read leaves the interrupt alone, that writes to count and unmapped locations are ignored, and that low bits are masked.

// File: rtl/itimer_pkg.sv
// Package: shared constants and types for the interval timer block.
// Assumes a 32-bit register word with the count field in the upper bits.
package itimer_pkg;

    localparam int WORD_W = 32;

    // Register kind selected inside one timer page.
    typedef enum logic [1:0] {
        RK_NONE  = 2'd0,
        RK_LIMIT = 2'd1,
        RK_COUNT = 2'd2
    } reg_kind_e;

endpackage

// File: rtl/itimer_decode.sv
// Module: address decoder for the timer pages.
// Maps a byte address to a timer index and a register kind. Pages 0..NCPU-1
// are processor timers and page NCPU is the shared timer. Bits 1:0 are ignored.
// Produces one-hot limit read and limit write strobes per timer.
module itimer_decode
    import itimer_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 12
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr,
    input  logic                    rd,
    output reg_kind_e               kind,
    output logic [$clog2(NCPU+1)-1:0] tsel,
    output logic [NCPU:0]           lim_wr,
    output logic [NCPU:0]           lim_rd
);
    localparam int NT    = NCPU + 1;
    localparam int PG_W  = ADDR_W - PAGE_W;
    localparam int OFS_W = PAGE_W - 2;
    localparam int SEL_W = $clog2(NT);

    logic [PG_W-1:0]  page;
    logic [OFS_W-1:0] word;
    logic             page_ok;

    // Split the address into page number and word offset.
    always_comb begin
        page    = addr[ADDR_W-1:PAGE_W];
        word    = addr[PAGE_W-1:2];
        page_ok = (page < PG_W'(NT));
    end

    // Classify the register within a valid page.
    always_comb begin
        kind = RK_NONE;
        tsel = '0;
        if (page_ok) begin
            tsel = SEL_W'(page);
            if (word == OFS_W'(0))
                kind = RK_LIMIT;
            else if (word == OFS_W'(1))
                kind = RK_COUNT;
        end
    end

    // One strobe per timer for limit reads and writes.
    generate
        for (genvar t = 0; t < NT; t++) begin : g_strobe
            assign lim_wr[t] = wr && (kind == RK_LIMIT) && (tsel == SEL_W'(t));
            assign lim_rd[t] = rd && (kind == RK_LIMIT) && (tsel == SEL_W'(t));
        end
    endgenerate

endmodule

// File: rtl/itimer_core.sv
// Module: one interval counter with a limit and a latched interrupt.
// The count starts at 1. On a tick it wraps to 1 and latches the interrupt
// when count+1 reaches a non-zero limit. With a zero limit it runs freely and
// steps from all-ones to 1. A limit write restarts the timer and takes
// priority over a tick. A limit read clears the interrupt unless a wrap
// happens on the same edge.
module itimer_core #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             lim_wr,
    input  logic             lim_rd,
    input  logic [CNT_W-1:0] wr_field,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] limit_q,
    output logic             irq_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W:0] cnt_inc;
    logic           hit;
    logic           at_max;

    // Wrap detection: count+1 reaching a non-zero limit.
    always_comb begin
        cnt_inc = {1'b0, count_q} + (CNT_W+1)'(1);
        hit     = (limit_q != '0) && (cnt_inc >= {1'b0, limit_q});
        at_max  = &count_q;
    end

    // Count and limit state with write priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= ONE;
            limit_q <= '0;
        end else if (lim_wr) begin
            count_q <= ONE;
            limit_q <= wr_field;
        end else if (tick) begin
            if (hit || at_max)
                count_q <= ONE;
            else
                count_q <= cnt_inc[CNT_W-1:0];
        end
    end

    // Interrupt latch: set on wrap, cleared by limit access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (lim_wr)
            irq_q <= 1'b0;
        else if (tick && hit)
            irq_q <= 1'b1;
        else if (lim_rd)
            irq_q <= 1'b0;
    end

endmodule

// File: rtl/itimer_rdmux.sv
// Module: read-data multiplexer for all timers.
// Places the selected count or limit field in the upper bits of the word.
// Bits below the field, unmapped locations and idle cycles read as zero.
module itimer_rdmux
    import itimer_pkg::*;
#(
    parameter int NT    = 5,
    parameter int CNT_W = 22
) (
    input  logic                      rd,
    input  reg_kind_e                 kind,
    input  logic [$clog2(NT)-1:0]     tsel,
    input  logic [NT-1:0][CNT_W-1:0]  counts,
    input  logic [NT-1:0][CNT_W-1:0]  limits,
    output logic [WORD_W-1:0]         rdata
);
    localparam int FRAC_W = WORD_W - CNT_W;

    logic [CNT_W-1:0] field;

    // Pick the field of the addressed timer.
    always_comb begin
        field = '0;
        for (int t = 0; t < NT; t++) begin
            if (tsel == $clog2(NT)'(t)) begin
                if (kind == RK_LIMIT)
                    field = limits[t];
                else if (kind == RK_COUNT)
                    field = counts[t];
            end
        end
    end

    // Shift the field into place and gate with the read strobe.
    always_comb begin
        rdata = (rd && kind != RK_NONE) ? {field, FRAC_W'(0)} : '0;
    end

endmodule

// File: rtl/itimer_block.sv
// Module: top of the interval timer block.
// Holds NCPU processor profiling timers (level-14 lines) and one shared timer
// (level-10 line) behind a word bus. Assumes tick_us is a single-cycle
// enable from an external microsecond prescaler, and that bus strobes are
// synchronous to clk.
module itimer_block
    import itimer_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int CNT_W  = 22,
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_us,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_sys_lvl10,
    output logic [NCPU-1:0]   irq_cpu_lvl14
);
    localparam int NT     = NCPU + 1;
    localparam int SEL_W  = $clog2(NT);
    localparam int FRAC_W = WORD_W - CNT_W;

    reg_kind_e                 kind;
    logic [SEL_W-1:0]          tsel;
    logic [NT-1:0]             lim_wr;
    logic [NT-1:0]             lim_rd;
    logic [NT-1:0][CNT_W-1:0]  counts;
    logic [NT-1:0][CNT_W-1:0]  limits;
    logic [NT-1:0]             irqs;
    logic [CNT_W-1:0]          wr_field;

    // Take only the count field from the write data; low bits are dropped.
    assign wr_field = bus_wdata[WORD_W-1:FRAC_W];

    itimer_decode #(
        .NCPU(NCPU), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)
    ) u_dec (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .kind(kind), .tsel(tsel), .lim_wr(lim_wr), .lim_rd(lim_rd)
    );

    // One timer per processor plus the shared timer at index NCPU.
    generate
        for (genvar t = 0; t < NT; t++) begin : g_tmr
            itimer_core #(.CNT_W(CNT_W)) u_core (
                .clk(clk), .rst_n(rst_n), .tick(tick_us),
                .lim_wr(lim_wr[t]), .lim_rd(lim_rd[t]), .wr_field(wr_field),
                .count_q(counts[t]), .limit_q(limits[t]), .irq_q(irqs[t])
            );
        end
    endgenerate

    itimer_rdmux #(.NT(NT), .CNT_W(CNT_W)) u_rd (
        .rd(bus_rd), .kind(kind), .tsel(tsel),
        .counts(counts), .limits(limits), .rdata(bus_rdata)
    );

    // Route interrupts to their fixed levels.
    assign irq_cpu_lvl14 = irqs[NCPU-1:0];
    assign irq_sys_lvl10 = irqs[NCPU];

endmodule

// File: rtl/itimer_chk.sv
// Module: assertion checker for itimer_block, observing ports only.
// Attached by the bind at the end of this file.
module itimer_chk #(
    parameter int NCPU   = 4,
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_us,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic              irq_sys_lvl10,
    input logic [NCPU-1:0]   irq_cpu_lvl14
);
    localparam int PG_W  = ADDR_W - PAGE_W;
    localparam int OFS_W = PAGE_W - 2;

    logic [PG_W-1:0]  pg;
    logic [OFS_W-1:0] wd;
    logic             sys_lim;
    logic             unmapped_pg;

    // Independent page decode for the properties.
    always_comb begin
        pg          = bus_addr[ADDR_W-1:PAGE_W];
        wd          = bus_addr[PAGE_W-1:2];
        sys_lim     = (pg == PG_W'(NCPU)) && (wd == '0);
        unmapped_pg = (pg > PG_W'(NCPU));
    end

    assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[9:0] == 10'd0);

    assert_rise_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_sys_lvl10) |-> $past(tick_us));

    assert_irq_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_sys_lvl10 && !(sys_lim && (bus_rd || bus_wr)) |=> irq_sys_lvl10);

    assert_wr_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && sys_lim |=> !irq_sys_lvl10);

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && unmapped_pg |-> bus_rdata == 32'd0);

    generate
        for (genvar i = 0; i < NCPU; i++) begin : g_cpu
            // R6: a limit read without a tick clears that processor's line.
            assert_rd_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
                bus_rd && !tick_us && pg == PG_W'(i) && wd == '0
                |=> !irq_cpu_lvl14[i]);
        end
    endgenerate

endmodule

bind itimer_block itimer_chk #(
    .NCPU(NCPU), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_sys_lvl10(irq_sys_lvl10), .irq_cpu_lvl14(irq_cpu_lvl14)
);

// File: tb/test_itimer_block.sv
module test_itimer_block;
    localparam int NCPU = 4;
    localparam int NV   = 8;

    // Vector table: target (0..3 cpu, 4 shared), limit field, ticks,
    // expected interrupt, expected count field.
    localparam int V_TGT [NV] = '{4, 1, 1, 4, 0, 3, 2, 4};
    localparam int V_LIM [NV] = '{2, 3, 3, 6, 6, 17, 0, 1};
    localparam int V_TCK [NV] = '{1, 1, 2, 4, 7, 16, 9, 3};
    localparam int V_IRQ [NV] = '{1, 0, 1, 0, 1, 1, 0, 1};
    localparam int V_CNT [NV] = '{1, 2, 1, 5, 3, 1, 10, 1};

    logic        clk = 0;
    logic        rst_n = 0;
    logic        tick_us = 0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 0;
    logic        bus_rd = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_sys_lvl10;
    logic [NCPU-1:0] irq_cpu_lvl14;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    itimer_block i_itimer_block (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_sys_lvl10(irq_sys_lvl10),
        .irq_cpu_lvl14(irq_cpu_lvl14)
    );

    function automatic logic [15:0] a_lim(int t);
        return 16'(t << 12);
    endfunction
    function automatic logic [15:0] a_cnt(int t);
        return 16'((t << 12) | 4);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle with optional tick; rdata captured before the edge.
    task automatic io(logic rd, logic wr, logic tk, logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; tick_us = tk; bus_addr = a; bus_wdata = d;
        #1 rv = bus_rdata;
        @(posedge clk);
        #1;
        bus_rd = 0; bus_wr = 0; tick_us = 0;
    endtask

    task automatic ticks(int n);
        if (n > 0) begin
            @(negedge clk);
            tick_us = 1;
            repeat (n) @(posedge clk);
            #1 tick_us = 0;
        end
    endtask

    function automatic logic irq_of(int t);
        return (t == NCPU) ? irq_sys_lvl10 : irq_cpu_lvl14[t];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: reset state
        io(1, 0, 0, a_cnt(4), 0); chk("R1 sys count", rv, 32'h400);
        io(1, 0, 0, a_lim(2), 0); chk("R1 cpu2 limit", rv, 32'h0);
        @(negedge clk);
        chk("R1 irqs", {27'd0, irq_sys_lvl10, irq_cpu_lvl14}, 32'd0);

        // R4/R8/R11: vector table walk
        for (int v = 0; v < NV; v++) begin
            io(0, 1, 0, a_lim(V_TGT[v]), 32'(V_LIM[v]) << 10);
            ticks(V_TCK[v]);
            @(negedge clk);
            chk($sformatf("R4 R8 R11 vec%0d irq", v), 32'(irq_of(V_TGT[v])), 32'(V_IRQ[v]));
            chk($sformatf("R11 vec%0d others", v),
                32'($countones({irq_sys_lvl10, irq_cpu_lvl14})), 32'(V_IRQ[v]));
            io(1, 0, 0, a_cnt(V_TGT[v]), 0);
            chk($sformatf("R4 R3 vec%0d count", v), rv, 32'(V_CNT[v]) << 10);
            io(1, 0, 0, a_lim(V_TGT[v]), 0);
            io(0, 1, 0, a_lim(V_TGT[v]), 0);
        end

        // R2: low bits dropped
        io(0, 1, 0, a_lim(4), 32'hFFFF_FFFF);
        io(1, 0, 0, a_lim(4), 0); chk("R2 limit mask", rv, 32'hFFFF_FC00);

        // R3: no tick, no change
        io(0, 1, 0, a_lim(4), 32'd100 << 10);
        ticks(3);
        repeat (5) @(posedge clk);
        io(1, 0, 0, a_cnt(4), 0); chk("R3 hold", rv, 32'd4 << 10);

        // R5: count read keeps irq; R6: limit read clears only its own timer
        io(0, 1, 0, a_lim(0), 32'd3 << 10);
        io(0, 1, 0, a_lim(2), 32'd3 << 10);
        ticks(2);
        io(1, 0, 0, a_cnt(0), 0);
        @(negedge clk); chk("R5 count read keeps irq", 32'(irq_cpu_lvl14), 32'b0101);
        io(1, 0, 0, a_lim(0), 0);
        @(negedge clk); chk("R6 clears own only", 32'(irq_cpu_lvl14), 32'b0100);

        // R6: read together with a wrap keeps irq (cpu2 count 1 -> tick -> 2)
        ticks(1);
        io(1, 0, 1, a_lim(2), 0);
        @(negedge clk); chk("R6 wrap beats read", 32'(irq_cpu_lvl14[2]), 32'd1);
        io(1, 0, 0, a_cnt(2), 0); chk("R6 wrap count", rv, 32'h400);

        // R7: write with tick restarts and clears
        io(0, 1, 1, a_lim(2), 32'd9 << 10);
        @(negedge clk); chk("R7 write clears irq", 32'(irq_cpu_lvl14[2]), 32'd0);
        io(1, 0, 0, a_cnt(2), 0); chk("R7 write beats tick", rv, 32'h400);

        // R10: count read-only
        ticks(2);
        io(0, 1, 0, a_cnt(2), 32'hABCD_0000);
        io(1, 0, 0, a_cnt(2), 0); chk("R10 count read-only", rv, 32'd3 << 10);

        // R9: unmapped offset and page
        io(0, 1, 0, 16'h4008, 32'hFFFF_FFFF);
        io(1, 0, 0, 16'h4008, 0); chk("R9 unmapped offset", rv, 32'd0);
        io(1, 0, 0, 16'h5000, 0); chk("R9 unmapped page", rv, 32'd0);
        io(1, 0, 0, a_lim(4), 0); chk("R9 sys limit intact", rv, 32'd100 << 10);
        io(1, 0, 0, a_cnt(2), 0); chk("R9 cpu2 count intact", rv, 32'd3 << 10);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule